// File: doc/BRIEF.md
# Pulse Width Measurement Timer

This block is one channel of a timer that measures the time between valid edges on its capture inputs. While its enable is high, a counter advances by one on every count strobe, which is a prescaled tick supplied from outside. A valid edge on a capture input stores the running count in that input's capture register, returns the counter to zero and raises a single-cycle capture interrupt. The captured value therefore measures the interval since the previous capture, in strobe periods.

If no edge arrives before the counter reaches its all-ones value, the next strobe wraps the counter to zero, raises a single-cycle overflow interrupt and sets a sticky overflow flag. Only the clear input removes the flag. Software counts the overflows and extends the measured interval by 2^CNT_W for each one. There are two capture inputs. Each has its own two-flop synchronizer, its own edge-select code and its own capture register. An edge that arrives between strobes is held and takes effect at the next strobe.

Top module: `pulse_width_timer`

## Requirements
- R1: While `run_en` is low, the counter is held at 0, no interrupt is raised and held edges are discarded. When `run_en` falls, `count` reads 0 one cycle later and the capture registers keep their values. Reset clears the counter, the flag, the interrupts and the capture registers.
- R2: While `run_en` is high, `count` increases by exactly one on each cycle in which `tick` is high, and it does not change in a cycle in which `tick` is low.
- R3: A valid edge on a capture input is seen through two synchronizer flops. On a strobe cycle, that input's capture register takes the current count, the counter becomes 0 and the matching `cap_irq` bit is high for one cycle. With `tick` held high, `cap_irq` is visible three clocks after the pin changes.
- R4: The 2-bit edge-select code of input i is `edge_sel[2i+1:2i]`. The code 00 detects no edge, 01 detects rising edges, 10 detects falling edges and 11 detects both. With code 00, pin activity raises no interrupt and leaves the capture register unchanged.
- R5: A strobe with the count at all-ones and no capture wraps the count to 0, pulses `ovf_irq` for one cycle and sets `ovf_flag`.
- R6: `ovf_flag` stays set until a cycle with `ovf_clr` high. If `ovf_clr` and an overflow fall in the same cycle, the flag ends up set.
- R7: When both inputs have a valid edge on the same strobe, both registers capture the same count and the counter clears once.
- R8: A capture on the strobe where the count is all-ones takes priority over the overflow: the capture register takes the all-ones value, and there is no overflow pulse and no flag change.
- R9: With D strobes between two captures, the second captured value is (D-1) mod 2^CNT_W and exactly floor((D-1)/2^CNT_W) overflow pulses fall between the two captures.
- R10: An edge detected on a cycle without `tick` is held and takes effect at the next strobe. With a strobe every other clock and captures 2m clocks apart, the captured value is m-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Counter enable |
| tick | input | 1 | Count strobe (prescaled tick) |
| cap_in | input | NUM_CAP | Capture input pins |
| edge_sel | input | 2*NUM_CAP | Edge-select code, two bits per input |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| count | output | CNT_W | Running counter value |
| cap_val | output | NUM_CAP*CNT_W | Capture registers, input i in bits [i*CNT_W +: CNT_W] |
| cap_irq | output | NUM_CAP | Single-cycle capture interrupt, one bit per input |
| ovf_irq | output | 1 | Single-cycle overflow interrupt |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two events can fall on the same strobe: a capture and an overflow when an edge reaches the all-ones count, and an overflow and a software flag clear. The bench waits until the count reads two below all-ones and then raises a pin, so that the synchronized edge meets the wrap exactly. The capture must win, with no overflow pulse. In a separate step it asserts the clear in the cycle before the wrap, and the flag must be read as set afterwards. Sweeps over the edge gap, run with an 8-bit counter, check every captured value against the arithmetic of R9 across several wraps.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/pwt_edge.sv
module pwt_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] sel,
    input  logic       run_en,
    input  logic       tick,
    output logic       evt
);
    import pwt_pkg::*;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
        logic                   pend;
    } edge_state_t;

    edge_state_t q, d;
    logic synced, hit;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], pin};
        synced = q.sync[SYNC_STAGES-1];
        d.last = synced;
        unique case (edge_sel_e'(sel))
            EDGE_RISE: hit = synced & ~q.last;
            EDGE_FALL: hit = ~synced & q.last;
            EDGE_BOTH: hit = synced ^ q.last;
            default:   hit = 1'b0;
        endcase
        evt = run_en & (hit | q.pend);
        // hold an edge that arrives between strobes
        if (!run_en || tick) d.pend = 1'b0;
        else                 d.pend = q.pend | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_evt_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !evt);
    p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !tick && q.pend) |=> q.pend);
endmodule

// File: rtl/pwt_core.sv
module pwt_core #(
    parameter int CNT_W   = 16,
    parameter int NUM_CAP = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_en,
    input  logic                     tick,
    input  logic [NUM_CAP-1:0]       evt,
    input  logic                     ovf_clr,
    output logic [CNT_W-1:0]         count,
    output logic [NUM_CAP*CNT_W-1:0] cap_val,
    output logic [NUM_CAP-1:0]       cap_irq,
    output logic                     ovf_irq,
    output logic                     ovf_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]                  cnt;
        logic [NUM_CAP-1:0][CNT_W-1:0]     caps;
        logic [NUM_CAP-1:0]                cap_irq;
        logic                              ovf_irq;
        logic                              flag;
    } core_state_t;

    core_state_t q, d;

    always_comb begin
        d         = q;
        d.cap_irq = '0;
        d.ovf_irq = 1'b0;
        if (!run_en) begin
            d.cnt = '0;
        end else if (tick) begin
            if (|evt) begin
                for (int i = 0; i < NUM_CAP; i++)
                    if (evt[i]) d.caps[i] = q.cnt;
                d.cap_irq = evt;
                d.cnt     = '0;
            end else if (q.cnt == CNT_MAX) begin
                d.cnt     = '0;
                d.ovf_irq = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        // set has priority over a same-cycle clear
        d.flag = d.ovf_irq | (q.flag & ~ovf_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign count    = q.cnt;
    assign cap_irq  = q.cap_irq;
    assign ovf_irq  = q.ovf_irq;
    assign ovf_flag = q.flag;

    for (genvar g = 0; g < NUM_CAP; g++) begin : g_out
        assign cap_val[g*CNT_W +: CNT_W] = q.caps[g];
    end

    p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (q.cnt == '0 && q.cap_irq == '0 && !q.ovf_irq));
    p_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !tick) |=> $stable(q.cnt));
    p_cap_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|q.cap_irq) |-> (q.cnt == '0));
    p_ovf_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovf_irq |-> q.flag);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !ovf_clr) |=> q.flag);
    p_pair_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (&q.cap_irq) |-> (q.caps[0] == q.caps[NUM_CAP-1]));
    p_cap_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|q.cap_irq) |-> !q.ovf_irq);
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
    parameter int CNT_W   = 16,
    parameter int NUM_CAP = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_en,
    input  logic                     tick,
    input  logic [NUM_CAP-1:0]       cap_in,
    input  logic [2*NUM_CAP-1:0]     edge_sel,
    input  logic                     ovf_clr,
    output logic [CNT_W-1:0]         count,
    output logic [NUM_CAP*CNT_W-1:0] cap_val,
    output logic [NUM_CAP-1:0]       cap_irq,
    output logic                     ovf_irq,
    output logic                     ovf_flag
);
    logic [NUM_CAP-1:0] evt;

    for (genvar g = 0; g < NUM_CAP; g++) begin : g_in
        pwt_edge #(.SYNC_STAGES(2)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (cap_in[g]),
            .sel    (edge_sel[2*g +: 2]),
            .run_en (run_en),
            .tick   (tick),
            .evt    (evt[g])
        );
    end

    pwt_core #(.CNT_W(CNT_W), .NUM_CAP(NUM_CAP)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .tick     (tick),
        .evt      (evt),
        .ovf_clr  (ovf_clr),
        .count    (count),
        .cap_val  (cap_val),
        .cap_irq  (cap_irq),
        .ovf_irq  (ovf_irq),
        .ovf_flag (ovf_flag)
    );
endmodule

// File: tb/tb_pulse_width_timer.sv
module tb_pulse_width_timer;
    localparam int W   = 8;
    localparam int MAX = (1 << W) - 1;

    logic clk = 0;
    logic rst_n = 0;
    logic run_en = 0;
    logic tick;
    logic [1:0] cap_in = 2'b00;
    logic [3:0] edge_sel = 4'b0000;
    logic ovf_clr = 0;
    logic [W-1:0] count;
    logic [2*W-1:0] cap_val;
    logic [1:0] cap_irq;
    logic ovf_irq, ovf_flag;
    wire [W-1:0] cap0 = cap_val[W-1:0];
    wire [W-1:0] cap1 = cap_val[2*W-1:W];

    int checks = 0, errs = 0, mchecks = 0, merrs = 0;
    int tick_mode = 0; // 0 always, 1 never, 2 alternate
    int prev_gap = -1;
    bit done = 0;

    pulse_width_timer #(.CNT_W(W), .NUM_CAP(2)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
        .cap_in(cap_in), .edge_sel(edge_sel), .ovf_clr(ovf_clr),
        .count(count), .cap_val(cap_val), .cap_irq(cap_irq),
        .ovf_irq(ovf_irq), .ovf_flag(ovf_flag)
    );

    always #4 clk = ~clk;

    initial tick = 1'b1;
    always @(negedge clk)
        tick <= (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? 1'b0 : ~tick;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R9 monitor: interval between captures on input 0 versus value and overflow pulses
    int since = 0, ovfs = 0;
    bit armed = 0;
    always @(posedge clk) begin
        #2;
        if (!rst_n || !run_en || tick_mode != 0) begin
            armed = 0; since = 0; ovfs = 0;
        end else begin
            since++;
            if (ovf_irq) ovfs++;
            if (cap_irq[0]) begin
                if (armed) begin
                    mchecks++;
                    if (cap0 !== (since - 1) % (MAX + 1) || ovfs != (since - 1) / (MAX + 1)) begin
                        merrs++;
                        $display("FAIL R9 actual=%0d/%0d expected=%0d/%0d",
                                 cap0, ovfs, (since - 1) % (MAX + 1), (since - 1) / (MAX + 1));
                    end
                end
                armed = 1; since = 0; ovfs = 0;
            end
        end
    end

    // one single-edge pulse on input 0, next leading edge g cycles later
    task automatic pulse_one(input int g, input bit fall);
        cap_in[0] = fall ? 1'b0 : 1'b1;
        step(3);
        chk("R3 irq", cap_irq[0], 1);
        chk("R3 count cleared", count, 0);
        if (prev_gap > 0) chk("R9 width", cap0, (prev_gap - 1) % (MAX + 1));
        cap_in[0] = fall ? 1'b1 : 1'b0;
        step(1);
        chk("R3 one-cycle irq", cap_irq[0], 0);
        step(g - 4);
        prev_gap = g;
    endtask

    task automatic set_sel(input logic [3:0] s, input logic [1:0] idle);
        edge_sel = 4'b0000;
        cap_in = idle;
        step(4);
        edge_sel = s;
        prev_gap = -1;
    endtask

    initial begin
        int seen;
        int c0;
        int lim;
        step(3);
        rst_n = 1;
        step(1);
        chk("R1 reset count", count, 0);
        chk("R1 reset flag", ovf_flag, 0);
        chk("R1 reset irq", {cap_irq, ovf_irq}, 0);
        chk("R1 reset cap", cap_val, 0);

        // R1: disabled, pin activity ignored
        edge_sel = 4'b0101;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            cap_in = ~cap_in;
            step(2);
            if (cap_irq != 0 || ovf_irq) seen++;
        end
        chk("R1 no irq while off", seen, 0);
        chk("R1 count held", count, 0);
        chk("R1 cap untouched", cap_val, 0);

        set_sel(4'b0000, 2'b00);
        run_en = 1;
        step(1);
        chk("R2 first tick", count, 1);
        c0 = count; step(10);
        chk("R2 ten ticks", count, c0 + 10);
        tick_mode = 1; step(1);
        c0 = count; step(5);
        chk("R2 no tick stable", count, c0);
        tick_mode = 2; step(1);
        c0 = count; step(10);
        chk("R2 half-rate ticks", count, c0 + 5);
        tick_mode = 0; step(1);

        // R3/R9: rising edges, sweep of gaps, then gaps across wraps
        set_sel(4'b0001, 2'b00);
        for (int g = 5; g <= 40; g++) pulse_one(g, 0);
        pulse_one(255, 0); pulse_one(256, 0); pulse_one(257, 0);
        pulse_one(300, 0); pulse_one(600, 0); pulse_one(20, 0);
        chk("R6 flag kept after wraps", ovf_flag, 1);

        // R4: falling edges
        set_sel(4'b0010, 2'b01);
        for (int g = 5; g <= 30; g++) pulse_one(g, 1);
        pulse_one(10, 1);

        // R4: both edges, square wave
        set_sel(4'b0011, 2'b00);
        for (int h = 4; h <= 24; h++) begin
            cap_in[0] = ~cap_in[0];
            step(3);
            chk("R4 both irq", cap_irq[0], 1);
            if (prev_gap > 0) chk("R4 both width", cap0, prev_gap - 1);
            step(h - 3);
            prev_gap = h;
        end

        // R4: code 00 ignores the pin
        set_sel(4'b0000, 2'b00);
        c0 = cap0; seen = 0;
        for (int i = 0; i < 20; i++) begin
            cap_in[0] = ~cap_in[0];
            step(3);
            if (cap_irq[0]) seen++;
        end
        chk("R4 off no irq", seen, 0);
        chk("R4 off cap kept", cap0, c0);

        // R7: simultaneous edges on both inputs
        set_sel(4'b0101, 2'b00);
        for (int k = 0; k < 3; k++) begin
            cap_in = 2'b11;
            step(3);
            chk("R7 both irq", cap_irq, 3);
            chk("R7 count cleared", count, 0);
            if (k > 0) begin
                chk("R7 cap0", cap0, 19);
                chk("R7 cap1", cap1, 19);
            end
            cap_in = 2'b00;
            step(17);
        end

        // R1: disable resets count, keeps captures
        run_en = 0;
        step(1);
        chk("R1 off count", count, 0);
        chk("R1 off cap0 kept", cap0, 19);
        chk("R1 off cap1 kept", cap1, 19);
        run_en = 1;
        set_sel(4'b0000, 2'b00);

        // R5/R6: overflow with same-cycle clear
        ovf_clr = 1; step(1); ovf_clr = 0;
        chk("R6 clear", ovf_flag, 0);
        lim = 0;
        while (count != MAX && lim < 600) begin step(1); lim++; end
        ovf_clr = 1;
        step(1);
        ovf_clr = 0;
        chk("R5 ovf irq", ovf_irq, 1);
        chk("R6 set wins", ovf_flag, 1);
        chk("R5 wrap", count, 0);
        step(1);
        chk("R5 one-cycle ovf", ovf_irq, 0);
        chk("R6 still set", ovf_flag, 1);
        step(100);
        chk("R6 sticky", ovf_flag, 1);
        ovf_clr = 1; step(1); ovf_clr = 0;
        chk("R6 cleared", ovf_flag, 0);
        step(10);
        chk("R6 stays clear", ovf_flag, 0);

        // R8: capture meets the wrap
        set_sel(4'b0001, 2'b00);
        ovf_clr = 1; step(1); ovf_clr = 0;
        lim = 0;
        while (count != MAX - 2 && lim < 600) begin step(1); lim++; end
        cap_in[0] = 1;
        step(3);
        chk("R8 capture irq", cap_irq[0], 1);
        chk("R8 captured max", cap0, MAX);
        chk("R8 no ovf irq", ovf_irq, 0);
        chk("R8 flag unchanged", ovf_flag, 0);
        chk("R8 count cleared", count, 0);
        cap_in[0] = 0;

        // R10: strobe every other clock
        tick_mode = 2;
        set_sel(4'b0001, 2'b00);
        for (int m = 6; m <= 12; m += 2) begin
            for (int r = 0; r < 2; r++) begin
                cap_in[0] = 1;
                seen = 0;
                for (int i = 0; i < 6; i++) begin
                    step(1);
                    if (cap_irq[0] && seen == 0) begin
                        seen = 1;
                        if (prev_gap > 0) chk("R10 half-rate width", cap0, prev_gap - 1);
                    end
                end
                chk("R10 capture seen", seen, 1);
                cap_in[0] = 0;
                step(2 * m - 6);
                prev_gap = m;
            end
        end
        tick_mode = 0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks + mchecks, errs + merrs);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks + mchecks + 1, errs + merrs + 1);
            $finish;
        end
    end
endmodule